// File: doc/BRIEF.md
# Clock Rate Calculator

This block works out, in hertz, the frequency of one chosen clock output of a clock tree from a snapshot of three control words. A mode word picks the PLL reference and says whether the main PLL is used. A PLL word holds the fractional-N multiplier and pre-divider fields. A divider word holds the integer post-divider fields. The caller drives a clock selector, the three words and a one-cycle start pulse. The block captures the inputs on that start and walks the reference and PLL arithmetic and then the chain of post-dividers. It finishes with a one-cycle done pulse, a 32-bit frequency and an error flag for an unsupported selector.

All division goes through one shared restoring divider that yields one quotient bit per cycle. Intermediate products are kept at 64 bits. A PLL-derived selection therefore takes a few hundred cycles. The constant selections finish two cycles after start. The block generates no clock itself. It is a rate oracle for timers and baud-rate logic.

Top module: `clk_rate_calc`

## Requirements
- R1: The reference is chosen by mode bits [2:1] (refSel). When refSel is 2, the reference is 0 if mode bit 3 (slow enable) is clear. If bit 3 is set, the reference is 32768 Hz, or 32768 × 1024 Hz when mode bit 4 (slow multiply) is also set. For any other refSel value, the reference is 26,000,000 Hz.
- R2: The main clock equals the reference when mode bit 7 (PLL bypass) is set or mode bit 0 (PLL enable) is clear. Otherwise it equals the PLL output of R3.
- R3: The PLL word fields are: signed 10-bit numerator mfn in bits [9:0], integer mfi in bits [13:10] (raised to 5 when below 5), denominator field in bits [25:16] with mfd = field + 1, and pre-divider field in bits [29:26] with pd = field + 1. The PLL output is ((2·(ref>>10)·f) / (mfd·pd)) << 10, where f = mfi·mfd + mfn. A negative f counts as 0, the division truncates, and the result is truncated to 32 bits.
- R4: Selector 1 returns main / (1 + divider bits [2:0]). Selector 2 returns main / (1 + divider bits [13:11]). Both are truncating divisions.
- R5: Selector 3 returns (main / (1 + divider bits [5:3])) / (1 + divider bits [7:6]), each step a truncating division.
- R6: Selector 0 returns 0 and selector 4 returns 32768. Selectors 0 to 4 leave the error flag at 0.
- R7: Selectors 5, 6 and 7 return 0 with the error flag set to 1.
- R8: Done is high for exactly one cycle per accepted start. The frequency and the error flag change only with done and hold their values until the next result.
- R9: A start pulse that arrives while a computation is in progress is ignored, and the running computation returns the result for its own captured inputs.
- R10: After reset, done, the frequency and the error flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; captures the selector and words when idle |
| clkSel | input | 3 | Selector: 0 none, 1 MCU, 2 HSP, 3 peripheral, 4 slow 32 kHz |
| modeWord | input | 32 | Reference and PLL use controls |
| divWord | input | 32 | Post-divider fields |
| pllWord | input | 32 | Main PLL fields |
| done | output | 1 | One-cycle result strobe |
| freqHz | output | 32 | Computed frequency in Hz |
| selErr | output | 1 | Unsupported selector flag, valid with done |

## Verification
Any error inside the block shows up as a wrong freqHz value at the done strobe of the request that hit it. A divider bit taken at the wrong step, a post-divider field misread or a wrong sign on the PLL numerator each give a value that differs from arithmetic computed in the bench. The bench runs the same computation across every reference choice, both PLL-use conditions, a set of PLL words and all eight selectors. It also sweeps every post-divider field value, so a corrupted field or stage is seen on the very first request that uses it. Control faults appear as a done pulse that lasts two cycles, a result that drifts after done, or a second start mid-run that changes the answer.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;

  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_NONE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MCU  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_HSP  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PER  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SLOW = 3'd4;

  typedef enum logic [1:0] {
    SRC_PLL   = 2'd0,
    SRC_POST1 = 2'd1,
    SRC_POST2 = 2'd2
  } divSrc_e;

  typedef struct packed {
    logic    capture;
    logic    divGo;
    divSrc_e divSrc;
    logic    loadRef;
    logic    loadPll;
    logic    loadQuo;
    logic    finish;
  } ctlStrobe_t;

endpackage

// File: rtl/clk_rate_div.sv
module clk_rate_div #(
  parameter int N_W = 64,
  parameter int D_W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           go,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [N_W-1:0] quotient
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [D_W-1:0]   remQ;
  logic [D_W-1:0]   dsrQ;
  logic [N_W-1:0]   quoQ;
  logic [CNT_W-1:0] cntQ;
  logic             busyQ;
  logic             doneQ;

  logic [D_W:0]   shifted;
  logic [D_W:0]   diff;
  logic           fits;
  logic [D_W-1:0] remNext;

  always_comb begin
    shifted = {remQ, quoQ[N_W-1]};
    diff    = shifted - {1'b0, dsrQ};
    fits    = shifted >= {1'b0, dsrQ};
    remNext = fits ? diff[D_W-1:0] : shifted[D_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ  <= '0;
      dsrQ  <= '0;
      quoQ  <= '0;
      cntQ  <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (go) begin
      remQ  <= '0;
      dsrQ  <= divisor;
      quoQ  <= dividend;
      cntQ  <= CNT_W'(N_W);
      busyQ <= 1'b1;
      doneQ <= 1'b0;
    end else if (busyQ) begin
      remQ <= remNext;
      quoQ <= {quoQ[N_W-2:0], fits};
      cntQ <= cntQ - 1'b1;
      if (cntQ == CNT_W'(1)) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign busy     = busyQ;
  assign done     = doneQ;
  assign quotient = quoQ;

  // R3: partial remainder always stays below the divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (remQ < dsrQ));

  // R9: the divider is never relaunched mid-run
  p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !go);

endmodule

// File: rtl/clk_rate_dpath.sv
module clk_rate_dpath
  import clk_rate_pkg::*;
#(
  parameter int unsigned XTAL_HZ    = 26000000,
  parameter int unsigned SLOW_HZ    = 32768,
  parameter int          SLOW_SHIFT = 10,
  parameter int          WORD_W     = 32,
  parameter int          PROD_W     = 64,
  parameter int          PLL_SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [SEL_W-1:0]  selIn,
  input  logic [WORD_W-1:0] modeIn,
  input  logic [WORD_W-1:0] divIn,
  input  logic [WORD_W-1:0] pllIn,
  output logic              pllActive,
  output logic              isDirect,
  output logic              isPer,
  output logic              divDone,
  output logic [WORD_W-1:0] freqHz,
  output logic              selErr
);
  localparam int REF_HI_W = WORD_W - PLL_SHIFT;
  localparam int PAD_NUM  = PROD_W - REF_HI_W - 1;

  logic [SEL_W-1:0] selQ;
  logic pllEnQ, slowEnQ, slowMulQ, bypassQ;
  logic [1:0] refSelQ;
  logic [2:0] mcuDivQ, maxDivQ, hspDivQ;
  logic [1:0] ipgDivQ;
  logic [9:0] mfnQ, mfdQ;
  logic [3:0] mfiQ, pdQ;

  logic [WORD_W-1:0] workQ;
  logic [WORD_W-1:0] freqQ;
  logic              errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0; pllEnQ <= 1'b0; refSelQ <= '0; slowEnQ <= 1'b0;
      slowMulQ <= 1'b0; bypassQ <= 1'b0;
      mcuDivQ <= '0; maxDivQ <= '0; hspDivQ <= '0; ipgDivQ <= '0;
      mfnQ <= '0; mfiQ <= '0; mfdQ <= '0; pdQ <= '0;
    end else if (strb.capture) begin
      selQ     <= selIn;
      pllEnQ   <= modeIn[0];
      refSelQ  <= modeIn[2:1];
      slowEnQ  <= modeIn[3];
      slowMulQ <= modeIn[4];
      bypassQ  <= modeIn[7];
      mcuDivQ  <= divIn[2:0];
      maxDivQ  <= divIn[5:3];
      ipgDivQ  <= divIn[7:6];
      hspDivQ  <= divIn[13:11];
      mfnQ     <= pllIn[9:0];
      mfiQ     <= pllIn[13:10];
      mfdQ     <= pllIn[25:16];
      pdQ      <= pllIn[29:26];
    end
  end

  logic unusedInBits;
  assign unusedInBits = ^{modeIn[WORD_W-1:8], modeIn[6:5], divIn[WORD_W-1:14],
                          divIn[10:8], pllIn[WORD_W-1:30], pllIn[15:14]};

  // reference selection
  logic [WORD_W-1:0] refHz;
  always_comb begin
    if (refSelQ == 2'd2) begin
      if (!slowEnQ)      refHz = '0;
      else if (slowMulQ) refHz = WORD_W'(SLOW_HZ) << SLOW_SHIFT;
      else               refHz = WORD_W'(SLOW_HZ);
    end else begin
      refHz = WORD_W'(XTAL_HZ);
    end
  end

  // PLL numerator and denominator
  logic [3:0]         mfiEff;
  logic [10:0]        mfdEff;
  logic [4:0]         pdEff;
  logic signed [31:0] factorS;
  logic [31:0]        factorU;
  logic [PROD_W-1:0]  pllNum;
  logic [WORD_W-1:0]  pllDen;

  always_comb begin
    mfiEff  = (mfiQ < 4'd5) ? 4'd5 : mfiQ;
    mfdEff  = {1'b0, mfdQ} + 11'd1;
    pdEff   = {1'b0, pdQ} + 5'd1;
    factorS = $signed({28'b0, mfiEff}) * $signed({21'b0, mfdEff})
            + $signed({{22{mfnQ[9]}}, mfnQ});
    factorU = factorS[31] ? 32'd0 : factorS;
    pllNum  = {{PAD_NUM{1'b0}}, refHz[WORD_W-1:PLL_SHIFT], 1'b0}
            * {{(PROD_W-32){1'b0}}, factorU};
    pllDen  = WORD_W'({21'b0, mfdEff} * {27'b0, pdEff});
  end

  // post-divider selection
  logic [2:0]        postFld;
  logic [WORD_W-1:0] divisorMux;
  logic [PROD_W-1:0] dividendMux;

  always_comb begin
    case (selQ)
      SEL_MCU: postFld = mcuDivQ;
      SEL_HSP: postFld = hspDivQ;
      default: postFld = maxDivQ;
    endcase
    case (strb.divSrc)
      SRC_PLL: begin
        dividendMux = pllNum;
        divisorMux  = pllDen;
      end
      SRC_POST1: begin
        dividendMux = {{(PROD_W-WORD_W){1'b0}}, workQ};
        divisorMux  = {{(WORD_W-3){1'b0}}, postFld} + 1'b1;
      end
      default: begin
        dividendMux = {{(PROD_W-WORD_W){1'b0}}, workQ};
        divisorMux  = {{(WORD_W-2){1'b0}}, ipgDivQ} + 1'b1;
      end
    endcase
  end

  logic              divBusy;
  logic [PROD_W-1:0] quotient;

  clk_rate_div #(.N_W(PROD_W), .D_W(WORD_W)) div_i (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (dividendMux),
    .divisor  (divisorMux),
    .busy     (divBusy),
    .done     (divDone),
    .quotient (quotient)
  );

  logic unusedQuo;
  assign unusedQuo = ^{quotient[PROD_W-1:WORD_W], divBusy};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workQ <= '0;
    end else if (strb.loadRef) begin
      workQ <= refHz;
    end else if (strb.loadPll) begin
      workQ <= {quotient[WORD_W-PLL_SHIFT-1:0], {PLL_SHIFT{1'b0}}};
    end else if (strb.loadQuo) begin
      workQ <= quotient[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqQ <= '0;
      errQ  <= 1'b0;
    end else if (strb.finish) begin
      case (selQ)
        SEL_NONE: begin freqQ <= '0;              errQ <= 1'b0; end
        SEL_SLOW: begin freqQ <= WORD_W'(SLOW_HZ); errQ <= 1'b0; end
        SEL_MCU, SEL_HSP, SEL_PER: begin freqQ <= workQ; errQ <= 1'b0; end
        default:  begin freqQ <= '0;              errQ <= 1'b1; end
      endcase
    end
  end

  assign pllActive = pllEnQ && !bypassQ;
  assign isDirect  = !(selQ == SEL_MCU || selQ == SEL_HSP || selQ == SEL_PER);
  assign isPer     = (selQ == SEL_PER);
  assign freqHz    = freqQ;
  assign selErr    = errQ;

  // R4: every division launched has a nonzero divisor
  p_den_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.divGo |-> (divisorMux != '0));

  // R7: error flag rises only with a result
  p_err_with_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $past(strb.finish));

  // R6: slow selector publishes the fixed rate
  p_slow_const_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.finish) && selQ == SEL_SLOW) |-> (freqQ == WORD_W'(SLOW_HZ)));

  // R8: result holds between finishes
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.finish) |-> $stable(freqQ));

endmodule

// File: rtl/clk_rate_ctrl.sv
module clk_rate_ctrl
  import clk_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       pllActive,
  input  logic       isDirect,
  input  logic       isPer,
  input  logic       divDone,
  output ctlStrobe_t strb,
  output logic       done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_WPLL, ST_P1GO, ST_WP1, ST_P2GO, ST_WP2, ST_FIN
  } state_e;

  state_e stateQ, stateD;
  logic   doneQ;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: if (start) begin
        strb.capture = 1'b1;
        stateD = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (isDirect) begin
          strb.finish = 1'b1;
          stateD = ST_IDLE;
        end else if (pllActive) begin
          strb.divGo  = 1'b1;
          strb.divSrc = SRC_PLL;
          stateD = ST_WPLL;
        end else begin
          strb.loadRef = 1'b1;
          stateD = ST_P1GO;
        end
      end
      ST_WPLL: if (divDone) begin
        strb.loadPll = 1'b1;
        stateD = ST_P1GO;
      end
      ST_P1GO: begin
        strb.divGo  = 1'b1;
        strb.divSrc = SRC_POST1;
        stateD = ST_WP1;
      end
      ST_WP1: begin
        strb.divSrc = SRC_POST1;
        if (divDone) begin
          strb.loadQuo = 1'b1;
          stateD = isPer ? ST_P2GO : ST_FIN;
        end
      end
      ST_P2GO: begin
        strb.divGo  = 1'b1;
        strb.divSrc = SRC_POST2;
        stateD = ST_WP2;
      end
      ST_WP2: begin
        strb.divSrc = SRC_POST2;
        if (divDone) begin
          strb.loadQuo = 1'b1;
          stateD = ST_FIN;
        end
      end
      default: begin
        strb.finish = 1'b1;
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.finish;
    end
  end

  assign done = doneQ;

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: no capture outside idle
  p_no_capture_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |-> !strb.capture);

endmodule

// File: rtl/clk_rate_calc.sv
module clk_rate_calc
  import clk_rate_pkg::*;
#(
  parameter int unsigned XTAL_HZ = 26000000,
  parameter int unsigned SLOW_HZ = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  clkSel,
  input  logic [31:0] modeWord,
  input  logic [31:0] divWord,
  input  logic [31:0] pllWord,
  output logic        done,
  output logic [31:0] freqHz,
  output logic        selErr
);
  ctlStrobe_t strb;
  logic pllActive, isDirect, isPer, divDone;

  clk_rate_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .pllActive (pllActive),
    .isDirect  (isDirect),
    .isPer     (isPer),
    .divDone   (divDone),
    .strb      (strb),
    .done      (done)
  );

  clk_rate_dpath #(.XTAL_HZ(XTAL_HZ), .SLOW_HZ(SLOW_HZ)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .selIn     (clkSel),
    .modeIn    (modeWord),
    .divIn     (divWord),
    .pllIn     (pllWord),
    .pllActive (pllActive),
    .isDirect  (isDirect),
    .isPer     (isPer),
    .divDone   (divDone),
    .freqHz    (freqHz),
    .selErr    (selErr)
  );

endmodule

// File: tb/clk_rate_calc_tb_top.sv
module clk_rate_calc_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  clkSel = '0;
  logic [31:0] modeWord = '0, divWord = '0, pllWord = '0;
  logic        done;
  logic [31:0] freqHz;
  logic        selErr;

  int checks = 0;
  int errors = 0;
  bit hung = 0;

  always #2.5 clk = ~clk;

  clk_rate_calc dut_i (
    .clk(clk), .rstN(rstN), .start(start), .clkSel(clkSel),
    .modeWord(modeWord), .divWord(divWord), .pllWord(pllWord),
    .done(done), .freqHz(freqHz), .selErr(selErr)
  );

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint refOf(input logic [31:0] m);
    if (m[2:1] == 2'd2) begin
      if (!m[3]) return 0;
      return m[4] ? 64'd32768 * 1024 : 64'd32768;
    end
    return 26000000;
  endfunction

  function automatic longint mainOf(input logic [31:0] m, input logic [31:0] p);
    longint r, mfi, mfd, pd, mfn, f, q;
    r = refOf(m);
    if (m[7] || !m[0]) return r;
    mfi = p[13:10]; if (mfi < 5) mfi = 5;
    mfd = longint'(p[25:16]) + 1;
    pd  = longint'(p[29:26]) + 1;
    mfn = p[9] ? longint'(p[9:0]) - 1024 : longint'(p[9:0]);
    f = mfi * mfd + mfn;
    if (f < 0) f = 0;
    q = (2 * (r >> 10) * f) / (mfd * pd);
    return (q << 10) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint expOf(input logic [2:0] s, input logic [31:0] m,
                                   input logic [31:0] d, input logic [31:0] p);
    longint mn;
    mn = mainOf(m, p);
    case (s)
      3'd0: return 0;
      3'd1: return mn / (longint'(d[2:0]) + 1);
      3'd2: return mn / (longint'(d[13:11]) + 1);
      3'd3: return (mn / (longint'(d[5:3]) + 1)) / (longint'(d[7:6]) + 1);
      3'd4: return 32768;
      default: return 0;
    endcase
  endfunction

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic runCalc(input logic [2:0] s, input logic [31:0] m,
                         input logic [31:0] d, input logic [31:0] p,
                         input string tag);
    bit seen;
    longint e;
    @(negedge clk);
    clkSel = s; modeWord = m; divWord = d; pllWord = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clkSel = ~s; modeWord = ~m;
    if (done) seen = 1; else waitDone(seen);
    check(seen, {tag, " R8 done seen"}, seen, 1);
    if (!seen) return;
    e = expOf(s, m, d, p);
    check(freqHz == e[31:0], tag, freqHz, e);
    check(selErr == (s > 3'd4), {tag, " R7 error flag"}, selErr, s > 3'd4);
    @(negedge clk);
    check(!done, {tag, " R8 single-cycle done"}, done, 0);
  endtask

  function automatic logic [31:0] modeOf(input int r, input int pc);
    logic [31:0] m;
    m = '0;
    case (r)
      0: m[2:1] = 2'd0;
      1: m[2:1] = 2'd2;
      2: begin m[2:1] = 2'd2; m[3] = 1'b1; end
      3: begin m[2:1] = 2'd2; m[4] = 1'b1; end
      default: begin m[2:1] = 2'd2; m[3] = 1'b1; m[4] = 1'b1; end
    endcase
    case (pc)
      0: m[0] = 1'b1;
      1: m[0] = 1'b0;
      default: begin m[0] = 1'b1; m[7] = 1'b1; end
    endcase
    return m;
  endfunction

  function automatic logic [31:0] pllOf(input int k);
    case (k)
      0: return 32'h0400_1800;
      1: return (32'd9 << 16) | (32'd2 << 10) | 32'h3FD;
      2: return (32'd5 << 10) | 32'd924;
      3: return 32'h8000_0000 | (32'd15 << 26) | (32'd1023 << 16) | (32'd15 << 10) | 32'd511;
      default: return (32'd15 << 10) | 32'd511;
    endcase
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    hung = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] dv;
    bit seen;
    // R10: reset state
    repeat (3) @(negedge clk);
    check(!done && freqHz == 0 && !selErr, "R10 reset state",
          {freqHz, 31'b0, done}, 0);
    rstN = 1'b1;

    // R1 R2 R3 R6 R7 sweep over references, PLL use, PLL words, selectors
    dv = 32'd1 | (32'd2 << 3) | (32'd1 << 6) | (32'd3 << 11);
    for (int r = 0; r < 5; r++)
      for (int pc = 0; pc < 3; pc++)
        for (int k = 0; k < 5; k++)
          for (int s = 0; s < 8; s++)
            runCalc(3'(s), modeOf(r, pc), dv, pllOf(k),
                    $sformatf("R1 R2 R3 R6 sweep r%0d pc%0d k%0d sel%0d", r, pc, k, s));

    // R4: MCU and HSP dividers, every field value
    for (int f = 0; f < 8; f++) begin
      runCalc(3'd1, modeOf(0, 1), 32'(f), 32'h0, $sformatf("R4 mcu div %0d", f));
      runCalc(3'd2, modeOf(0, 1), 32'(f) << 11, 32'h0, $sformatf("R4 hsp div %0d", f));
    end
    // R5: bus then peripheral divider chain
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 4; b++)
        runCalc(3'd3, modeOf(0, 1), (32'(a) << 3) | (32'(b) << 6), 32'h0,
                $sformatf("R5 chain %0d %0d", a, b));

    // R9: start during a busy run is ignored
    @(negedge clk);
    clkSel = 3'd1; modeWord = modeOf(0, 0); divWord = 32'd2; pllWord = pllOf(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    clkSel = 3'd4; modeWord = modeOf(0, 1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    check(seen && freqHz == expOf(3'd1, modeOf(0, 0), 32'd2, pllOf(0)),
          "R9 busy start ignored", freqHz, expOf(3'd1, modeOf(0, 0), 32'd2, pllOf(0)));
    // R8: result held after done until the next start
    repeat (6) @(negedge clk);
    check(!done && freqHz == expOf(3'd1, modeOf(0, 0), 32'd2, pllOf(0)),
          "R8 result held", freqHz, expOf(3'd1, modeOf(0, 0), 32'd2, pllOf(0)));

    if (!hung) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule